// File: doc/BRIEF.md
# Relocating Address Guard

This block stands between the instruction sequencer of a multiprogrammed processor and its memory port. In user mode it turns every address that a program issues, which is relative to the start of the program's region, into a physical address by adding the program's region base. Two of those addresses are also compared against the last block of the region: the instruction fetch address and the indexed operand address. Region base and region end are held as 64-word block numbers and can be written only while the processor runs supervisor code.

A failed comparison does not stop the instruction. The sequencer still steps through all of its phases, but the guard withholds the memory enable for every later access in that instruction. At the fetch phase of the following instruction the guard raises a trap request so that the supervisor is entered. Accumulator and index-register references never go through the comparison, because the first eight words always lie inside a region of at least one block. In supervisor mode nothing is compared. Each of the three instruction address fields can be relocated or left absolute on its own, and instruction fetches are never relocated.

The sequencer supplies the phase number, which has values 1 to 5, with 0 meaning idle. It also supplies the kind of each access and, from phase 3 on, the indexed operand address.

Top module: `addrGuard`

## Requirements
- R1: After reset the base and end block numbers are 0, no failure is latched, `trapReq` and `accessBlocked` are 0, and `physAddr` equals `relAddr` for a user-mode access.
- R2: A cycle with `regLoad`=1 and `supMode`=1 writes `baseIn` and `limitIn` into the region registers at the clock edge. With `supMode`=0 the load has no effect, as seen at `physAddr`.
- R3: In user mode, `physAddr` = (`relAddr` + base×64) mod 2^15 for every access kind. The kind codes are 0 fetch, 1 accumulator field, 2 index field, 3 operand field.
- R4: At the end of a user-mode phase-1 cycle that has `memReq`=1 and kind 0, a failure is latched when (`relAddr` + base×64) divided by 64 exceeds the end block. This includes sums of 2^15 or more. The check result replaces any earlier latched value.
- R5: At the end of a user-mode phase-3 cycle, a failure is latched when (`idxAddr` + base×64) divided by 64 exceeds the end block. An earlier failure stays latched.
- R6: While a failure is latched, `memEn` is 0 and `accessBlocked` is 1. Otherwise `memEn` follows `memReq`. The access in the phase whose check fails still gets its enable.
- R7: `trapReq` is 1 exactly in a phase-1 cycle that begins with a failure latched. The latch is rewritten at the end of that cycle.
- R8: Kind 1 and kind 2 accesses are never compared and never latch a failure, even when the end block lies below the base.
- R9: In supervisor mode no failure is latched. Fetches are not relocated. Kinds 1, 2 and 3 are relocated only when `supRelocMask` bit 0, 1 and 2 is set, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supMode | input | 1 | 1 while supervisor code runs |
| regLoad | input | 1 | Write strobe for the region registers |
| baseIn | input | 9 | New region base block number |
| limitIn | input | 9 | New region end block number |
| phase | input | 3 | Instruction phase, 1 to 5, 0 idle |
| memReq | input | 1 | The sequencer wants a memory access this cycle |
| fieldKind | input | 2 | Kind of the current access (0 fetch, 1 accumulator, 2 index, 3 operand) |
| relAddr | input | 15 | Program-relative address of the current access |
| idxAddr | input | 15 | Indexed operand address, valid from phase 3 |
| supRelocMask | input | 3 | Supervisor relocation enables for accumulator, index and operand fields |
| physAddr | output | 15 | Physical address for the current access |
| memEn | output | 1 | Memory access enable |
| trapReq | output | 1 | Request to enter the supervisor |
| accessBlocked | output | 1 | A bounds failure is latched for this instruction |

## Verification
Two functions can land in the same cycle at the start of an instruction. These are the trap for the previous instruction's failure and the fetch check of the new one. The bench provokes this by running a failing fetch directly after a failing operand check, and a passing fetch directly after a failing one. In the trap cycle it expects `trapReq` high with the fetch enable withheld. One cycle later the expected latch comes only from the new fetch result. A second collision, a phase-3 access that fails its own check, is judged by expecting the enable in that phase and no enable from phase 4 on.

// File: rtl/guardPkg.sv
package guardPkg;
  localparam logic [2:0] PH_FETCH = 3'd1;
  localparam logic [2:0] PH_OPND1 = 3'd3;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_ACC   = 2'd1,
    KIND_IDX   = 2'd2,
    KIND_OPND  = 2'd3
  } fieldKind_e;

  typedef struct packed {
    logic relocEn;
    logic loadRegs;
  } pathStrobe_t;
endpackage

// File: rtl/guardPath.sv
module guardPath
  import guardPkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BLK_SH = 6,
  localparam int BLK_W = ADDR_W - BLK_SH
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobe_t       strobe,
  input  logic [BLK_W-1:0]  baseIn,
  input  logic [BLK_W-1:0]  limitIn,
  input  logic [ADDR_W-1:0] relAddr,
  input  logic [ADDR_W-1:0] idxAddr,
  output logic [ADDR_W-1:0] physAddr,
  output logic              accOver,
  output logic              idxOver
);
  logic [BLK_W-1:0] baseQ;
  logic [BLK_W-1:0] limitQ;
  logic [ADDR_W:0]  baseWide;
  logic [ADDR_W:0]  accSum;
  logic [ADDR_W:0]  idxSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      limitQ <= '0;
    end else if (strobe.loadRegs) begin
      baseQ  <= baseIn;
      limitQ <= limitIn;
    end
  end

  assign baseWide = {1'b0, baseQ, {BLK_SH{1'b0}}};

  always_comb begin
    accSum = {1'b0, relAddr};
    if (strobe.relocEn) accSum = {1'b0, relAddr} + baseWide;
  end

  assign idxSum   = {1'b0, idxAddr} + baseWide;
  assign physAddr = accSum[ADDR_W-1:0];
  assign accOver  = accSum[ADDR_W] || (accSum[ADDR_W-1:BLK_SH] > limitQ);
  assign idxOver  = idxSum[ADDR_W] || (idxSum[ADDR_W-1:BLK_SH] > limitQ);

  AST_REGS_LOAD_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(baseQ) || !$stable(limitQ)) |-> $past(strobe.loadRegs)) else $error("region registers changed without load"); // R2
endmodule

// File: rtl/guardCtrl.sv
module guardCtrl
  import guardPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supMode,
  input  logic        regLoad,
  input  logic [2:0]  phase,
  input  logic        memReq,
  input  logic [1:0]  fieldKind,
  input  logic [2:0]  supRelocMask,
  input  logic        accOver,
  input  logic        idxOver,
  output pathStrobe_t strobe,
  output logic        memEn,
  output logic        trapReq,
  output logic        failQ
);
  fieldKind_e kind;
  logic       fetchFail;
  logic       failNext;

  assign kind = fieldKind_e'(fieldKind);

  always_comb begin
    strobe.loadRegs = regLoad && supMode;
    strobe.relocEn  = 1'b1;
    if (supMode) begin
      unique case (kind)
        KIND_FETCH: strobe.relocEn = 1'b0;
        KIND_ACC:   strobe.relocEn = supRelocMask[0];
        KIND_IDX:   strobe.relocEn = supRelocMask[1];
        KIND_OPND:  strobe.relocEn = supRelocMask[2];
        default:    strobe.relocEn = 1'b0;
      endcase
    end
  end

  assign fetchFail = !supMode && memReq && (kind == KIND_FETCH) && accOver;

  always_comb begin
    failNext = failQ;
    if (phase == PH_FETCH) failNext = fetchFail;
    else if (phase == PH_OPND1 && !supMode) failNext = failQ || idxOver;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) failQ <= 1'b0;
    else       failQ <= failNext;
  end

  assign memEn   = memReq && !failQ;
  assign trapReq = (phase == PH_FETCH) && failQ;

  AST_BLOCKED_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    failQ |-> !memEn) else $error("access enabled after failure"); // R6
  AST_FAIL_AT_CHECK_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failQ) |-> ($past(phase) == PH_FETCH || $past(phase) == PH_OPND1)) else $error("failure latched outside check phases"); // R4
  AST_SUP_NEVER_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failQ) |-> !$past(supMode)) else $error("failure latched in supervisor mode"); // R9
  AST_TRAP_AT_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (phase == PH_FETCH)) else $error("trap outside fetch phase"); // R7
  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (failQ && phase != PH_FETCH) |=> failQ) else $error("failure dropped mid instruction"); // R5
endmodule

// File: rtl/addrGuard.sv
module addrGuard
  import guardPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supMode,
  input  logic        regLoad,
  input  logic [8:0]  baseIn,
  input  logic [8:0]  limitIn,
  input  logic [2:0]  phase,
  input  logic        memReq,
  input  logic [1:0]  fieldKind,
  input  logic [14:0] relAddr,
  input  logic [14:0] idxAddr,
  input  logic [2:0]  supRelocMask,
  output logic [14:0] physAddr,
  output logic        memEn,
  output logic        trapReq,
  output logic        accessBlocked
);
  localparam int ADDR_W = 15;
  localparam int BLK_SH = 6;

  pathStrobe_t strobe;
  logic        accOver;
  logic        idxOver;

  guardCtrl uCtrl (
    .clk(clk), .rstN(rstN), .supMode(supMode), .regLoad(regLoad),
    .phase(phase), .memReq(memReq), .fieldKind(fieldKind),
    .supRelocMask(supRelocMask), .accOver(accOver), .idxOver(idxOver),
    .strobe(strobe), .memEn(memEn), .trapReq(trapReq), .failQ(accessBlocked)
  );

  guardPath #(.ADDR_W(ADDR_W), .BLK_SH(BLK_SH)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseIn(baseIn),
    .limitIn(limitIn), .relAddr(relAddr), .idxAddr(idxAddr),
    .physAddr(physAddr), .accOver(accOver), .idxOver(idxOver)
  );
endmodule

// File: tb/addrGuard_test.sv
module addrGuard_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        supMode = 1'b0, regLoad = 1'b0, memReq = 1'b0;
  logic [8:0]  baseIn = '0, limitIn = '0;
  logic [2:0]  phase = '0, supRelocMask = '0;
  logic [1:0]  fieldKind = '0;
  logic [14:0] relAddr = '0, idxAddr = '0;
  logic [14:0] physAddr;
  logic        memEn, trapReq, accessBlocked;

  int checks = 0;
  int failures = 0;
  int mBase = 0, mLimit = 0;
  bit mFail = 0;

  always #5 clk = ~clk;

  addrGuard uut (.*);

  function automatic bit overOf(int addr);
    return ((addr + mBase * 64) / 64) > mLimit;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit sup, bit ld, int ph, bit req, int kind,
                      int rel, int idx, int mask);
    int reloc;
    @(negedge clk);
    supMode = sup; regLoad = ld; phase = 3'(ph); memReq = req;
    fieldKind = 2'(kind); relAddr = 15'(rel); idxAddr = 15'(idx);
    supRelocMask = 3'(mask);
    #4;
    reloc = !sup ? 1 : (kind == 0 ? 0 : (mask >> (kind - 1)) & 1);
    chk(tag, "physAddr", int'(physAddr), (rel + (reloc != 0 ? mBase * 64 : 0)) % 32768);
    chk(tag, "memEn", int'(memEn), int'(req && !mFail));
    chk(tag, "trapReq", int'(trapReq), int'(ph == 1 && mFail));
    chk(tag, "accessBlocked", int'(accessBlocked), int'(mFail));
    @(posedge clk);
    if (ph == 1) mFail = !sup && req && kind == 0 && overOf(rel);
    else if (ph == 3 && !sup) mFail = mFail || overOf(idx);
    if (ld && sup) begin mBase = baseIn; mLimit = limitIn; end
  endtask

  task automatic loadRegs(string tag, bit sup, int b, int l);
    baseIn = 9'(b); limitIn = 9'(l);
    step(tag, sup, 1, 0, 0, 0, 0, 0, 0);
    step(tag, 0, 0, 0, 0, 1, 64, 0, 0);
  endtask

  task automatic instr(string tag, bit sup, int fetch, int idx, int mask, bit indexed);
    step(tag, sup, 0, 1, 1, 0, fetch, 0, mask);
    if (indexed) step(tag, sup, 0, 2, 1, 2, 1, 0, mask);
    step(tag, sup, 0, 3, 1, 3, idx, idx, mask);
    step(tag, sup, 0, 4, 1, 1, 2, idx, mask);
    step(tag, sup, 0, 5, 1, 3, idx, idx, mask);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    step("R1", 0, 0, 0, 0, 3, 1234, 0, 0);
    loadRegs("R2", 1, 5, 9);
    instr("R3", 0, 10, 300, 0, 1);
    instr("R4", 0, 400, 20, 0, 0);
    instr("R7", 0, 11, 22, 0, 1);
    instr("R5", 0, 12, 5000, 0, 1);
    instr("R7", 0, 4000, 30, 0, 0);
    instr("R6", 0, 13, 14, 0, 0);
    loadRegs("R2", 0, 100, 200);
    instr("R3", 0, 250, 260, 0, 0);
    loadRegs("R2", 1, 500, 511);
    instr("R5", 0, 20, 20000, 0, 1);
    instr("R4", 0, 8000, 20, 0, 0);
    instr("R6", 0, 21, 22, 0, 0);
    for (int m = 0; m < 8; m++) instr("R9", 1, 30000, 29000, m, 1);
    loadRegs("R2", 1, 20, 10);
    step("R8", 0, 0, 2, 1, 2, 3, 0, 0);
    step("R8", 0, 0, 4, 1, 1, 7, 0, 0);
    step("R8", 0, 0, 5, 1, 1, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    loadRegs("R2", 1, 0, 0);
    instr("R3", 0, 63, 0, 0, 1);
    instr("R4", 0, 64, 0, 0, 0);
    instr("R7", 0, 1, 1, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule